// File: doc/BRIEF.md
# Extended Register Area Access Controller

This block sits next to the register-file decoder of a small CPU and decides, access by access, which special-function-register area the decoder should use. An extend instruction opens a short window that lasts for a programmed number of following retired instructions. Inside that window, short register addresses and direct bit addresses are steered to the extended area. Long 16-bit addresses and indirect addresses ignore the window and always decode by their absolute page. The general-purpose registers, which both areas share, are never redirected.

The block also produces the byte write enables for the 16-bit registers. A byte write to a special-function register writes the addressed byte and clears the other byte of the word. Bit operations are only legal on the upper half of each register block. A bit operation that targets the lower half raises an error pulse, and the write is suppressed.

Top module: `extreg_area_ctl`

## Requirements
- R1: After reset the window is closed, so a short access gives `area_sel` = 0. A reset that arrives while a window is open closes it.
- R2: If `ext_issue` is high at a clock edge with `ext_cnt` = n, the window covers the next n+1 retired instructions. While it is open, short accesses (mode 0) give `area_sel` = 1. After the (n+1)th `retire` edge, they give 0 again.
- R3: A cycle with `retire` low does not use up any of the window.
- R4: An `ext_issue` while the window is open reloads the window from the new `ext_cnt`. Any remaining count is discarded.
- R5: Long (mode 2) and indirect (mode 3) accesses ignore the window. They give `area_sel` = 1 exactly when `acc_addr[15:9]` equals `EXT_PAGE` (default 7'h78). `reg_off` is `acc_addr[8:1]` for these modes and `acc_addr[7:0]` for modes 0 and 1.
- R6: Short and bit accesses whose offset has `acc_addr[7:4]` = 4'hF are general-purpose registers. They always give `area_sel` = 0.
- R7: A bit access (mode 1) inside an open window gives `area_sel` = 1, unless it targets a general-purpose register.
- R8: A bit access with `acc_addr[7]` = 0 pulses `bit_err` while `acc_valid` is high, and forces `we` = 2'b00. With `acc_addr[7]` = 1 there is no error, and a write gives `we` = 2'b11.
- R9: A valid byte write (`wr_byte` = 1) to a special-function register gives `we` = 2'b10 when `byte_hi` = 1 and 2'b01 otherwise, with `clr_other` = 1.
- R10: A byte write to a general-purpose register sets the same one-hot `we` with `clr_other` = 0. A word write gives `we` = 2'b11 with `clr_other` = 0.
- R11: Long or indirect writes whose page is neither `EXT_PAGE` nor `STD_PAGE` (default 7'h7F) give `we` = 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_issue | input | 1 | Extend instruction retires this cycle |
| ext_cnt | input | CNT_W | Window length minus one |
| retire | input | 1 | Instruction-retire strobe |
| acc_valid | input | 1 | Register access present |
| acc_mode | input | 2 | 0 short, 1 bit, 2 long, 3 indirect |
| acc_addr | input | 16 | Short offset in [7:0], or absolute address |
| wr | input | 1 | Access writes |
| wr_byte | input | 1 | Byte-sized write |
| byte_hi | input | 1 | Byte write targets the high byte |
| area_sel | output | 1 | 1 selects the extended area |
| reg_off | output | 8 | Word offset within the register block |
| we | output | 2 | Byte write enables, bit 1 is the high byte |
| clr_other | output | 1 | Clear the byte that is not written |
| bit_err | output | 1 | Illegal bit-address pulse |

## Verification
The bench builds the block with its default parameters. With a 2-bit count field, every window length from one to four instructions is within reach, including the shortest and the longest. With the default pages of 7'h78 and 7'h7F, a long address of 16'hF0xx lands in the extended area, 16'hFExx lands in the standard area, and low addresses fall outside both areas. Those three cases are enough to reach every branch of the absolute decode.

// File: rtl/extreg_area_ctl.sv
module extreg_area_ctl #(
  parameter int unsigned CNT_W    = 2,
  parameter logic [6:0]  EXT_PAGE = 7'h78,
  parameter logic [6:0]  STD_PAGE = 7'h7F,
  parameter logic [3:0]  GPR_NIB  = 4'hF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_issue,
  input  logic [CNT_W-1:0] ext_cnt,
  input  logic             retire,
  input  logic             acc_valid,
  input  logic [1:0]       acc_mode,
  input  logic [15:0]      acc_addr,
  input  logic             wr,
  input  logic             wr_byte,
  input  logic             byte_hi,
  output logic             area_sel,
  output logic [7:0]       reg_off,
  output logic [1:0]       we,
  output logic             clr_other,
  output logic             bit_err
);
  localparam int unsigned WIN_W = CNT_W + 1;

  logic [WIN_W-1:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      win_cnt <= '0;
    else if (ext_issue)
      win_cnt <= {1'b0, ext_cnt} + WIN_W'(1);
    else if (retire && win_cnt != '0)
      win_cnt <= win_cnt - WIN_W'(1);
  end

  logic win_open, is_bit, is_abs, gpr_hit, abs_hit, bit_bad, wr_ok, byte_mode;

  assign win_open  = (win_cnt != '0);
  assign is_bit    = (acc_mode == 2'd1);
  assign is_abs    = acc_mode[1];
  assign gpr_hit   = !is_abs && (acc_addr[7:4] == GPR_NIB);
  assign abs_hit   = (acc_addr[15:9] == EXT_PAGE) || (acc_addr[15:9] == STD_PAGE);
  assign bit_bad   = is_bit && !acc_addr[7];

  assign area_sel  = is_abs ? (acc_addr[15:9] == EXT_PAGE) : (win_open && !gpr_hit);
  assign reg_off   = is_abs ? acc_addr[8:1] : acc_addr[7:0];

  assign bit_err   = acc_valid && bit_bad;
  assign wr_ok     = acc_valid && wr && !bit_bad && !(is_abs && !abs_hit);
  assign byte_mode = wr_byte && !is_bit;

  assign we        = !wr_ok     ? 2'b00 :
                     byte_mode ? (byte_hi ? 2'b10 : 2'b01) : 2'b11;
  assign clr_other = wr_ok && byte_mode && !gpr_hit;
endmodule

// File: rtl/extreg_area_ctl_chk.sv
module extreg_area_ctl_chk #(
  parameter int unsigned CNT_W    = 2,
  parameter logic [6:0]  EXT_PAGE = 7'h78
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_issue,
  input logic [CNT_W-1:0] ext_cnt,
  input logic             retire,
  input logic [1:0]       acc_mode,
  input logic [15:0]      acc_addr,
  input logic             area_sel,
  input logic [1:0]       we,
  input logic             clr_other,
  input logic             bit_err,
  input logic [CNT_W:0]   win_cnt
);
  localparam int unsigned WIN_W = CNT_W + 1;

  assert_window_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_issue |=> win_cnt == WIN_W'($past(ext_cnt)) + WIN_W'(1));

  assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire && !ext_issue) |=> $stable(win_cnt));

  assert_abs_decode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mode[1] |-> area_sel == (acc_addr[15:9] == EXT_PAGE));

  assert_gpr_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_mode[1] && acc_addr[7:4] == 4'hF) |-> !area_sel);

  assert_bit_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> we == 2'b00);

  assert_clear_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_other |-> $countones(we) == 1);
endmodule

bind extreg_area_ctl extreg_area_ctl_chk #(.CNT_W(CNT_W), .EXT_PAGE(EXT_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_issue(ext_issue), .ext_cnt(ext_cnt),
  .retire(retire), .acc_mode(acc_mode), .acc_addr(acc_addr),
  .area_sel(area_sel), .we(we), .clr_other(clr_other), .bit_err(bit_err),
  .win_cnt(win_cnt)
);

// File: tb/sim_extreg_area_ctl.sv
module sim_extreg_area_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_issue = 0, retire = 0, acc_valid = 0, wr = 0, wr_byte = 0, byte_hi = 0;
  logic [1:0] ext_cnt = 0, acc_mode = 0;
  logic [15:0] acc_addr = 0;
  logic area_sel, clr_other, bit_err;
  logic [7:0] reg_off;
  logic [1:0] we;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  extreg_area_ctl u0 (.*);

  // fields: req[29:26] mode[25:24] addr[23:8] wr[7] wb[6] bh[5] area[4] we[3:2] clr[1] err[0]
  localparam int NV = 11;
  localparam logic [29:0] VEC [0:NV-1] = '{
    {4'd1,  2'd0, 16'h0040, 3'b000, 1'b0, 2'b00, 1'b0, 1'b0}, // R1
    {4'd5,  2'd2, 16'hF042, 3'b000, 1'b1, 2'b00, 1'b0, 1'b0}, // R5
    {4'd5,  2'd3, 16'hFE10, 3'b000, 1'b0, 2'b00, 1'b0, 1'b0}, // R5
    {4'd10, 2'd2, 16'hF042, 3'b100, 1'b1, 2'b11, 1'b0, 1'b0}, // R10
    {4'd9,  2'd0, 16'h0022, 3'b110, 1'b0, 2'b01, 1'b1, 1'b0}, // R9
    {4'd9,  2'd2, 16'hFE11, 3'b111, 1'b0, 2'b10, 1'b1, 1'b0}, // R9
    {4'd10, 2'd0, 16'h00F3, 3'b111, 1'b0, 2'b10, 1'b0, 1'b0}, // R10
    {4'd8,  2'd1, 16'h0030, 3'b100, 1'b0, 2'b00, 1'b0, 1'b1}, // R8
    {4'd8,  2'd1, 16'h0090, 3'b100, 1'b0, 2'b11, 1'b0, 1'b0}, // R8
    {4'd11, 2'd2, 16'h1234, 3'b100, 1'b0, 2'b00, 1'b0, 1'b0}, // R11
    {4'd11, 2'd3, 16'h8000, 3'b110, 1'b0, 2'b00, 1'b0, 1'b0}  // R11
  };

  task automatic chk(input int req, input logic ea, input logic [1:0] ewe,
                     input logic eclr, input logic eerr);
    checks++;
    if (area_sel !== ea || we !== ewe || clr_other !== eclr || bit_err !== eerr) begin
      fails++;
      $display("FAIL R%0d: got area=%b we=%b clr=%b err=%b, want area=%b we=%b clr=%b err=%b",
               req, area_sel, we, clr_other, bit_err, ea, ewe, eclr, eerr);
    end
  endtask

  task automatic acc(input logic [1:0] m, input logic [15:0] a, input logic w,
                     input logic wb, input logic bh);
    acc_valid = 1; acc_mode = m; acc_addr = a; wr = w; wr_byte = wb; byte_hi = bh;
    #2;
  endtask

  task automatic edge_step(input logic ret, input logic ext, input logic [1:0] n);
    retire = ret; ext_issue = ext; ext_cnt = n;
    @(posedge clk); @(negedge clk);
    retire = 0; ext_issue = 0;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: run did not end");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][25:24], VEC[i][23:8], VEC[i][7], VEC[i][6], VEC[i][5]);
      chk(int'(VEC[i][29:26]), VEC[i][4], VEC[i][3:2], VEC[i][1], VEC[i][0]);
      checks++;
      if (reg_off !== (VEC[i][25] ? VEC[i][16:9] : VEC[i][15:8])) begin
        fails++;
        $display("FAIL R5: reg_off got %h want %h", reg_off,
                 VEC[i][25] ? VEC[i][16:9] : VEC[i][15:8]);
      end
    end

    // R2: count 1 -> two instructions in window
    edge_step(1, 1, 2'd1);
    acc(2'd0, 16'h0040, 0, 0, 0); chk(2, 1, 2'b00, 0, 0);
    edge_step(0, 0, 0);
    acc(2'd0, 16'h0040, 0, 0, 0); chk(3, 1, 2'b00, 0, 0); // R3 stall kept window
    acc(2'd2, 16'hFE10, 0, 0, 0); chk(5, 0, 2'b00, 0, 0); // R5 ignores window
    acc(2'd0, 16'h00F5, 0, 0, 0); chk(6, 0, 2'b00, 0, 0); // R6 GPR bypass
    acc(2'd1, 16'h0090, 0, 0, 0); chk(7, 1, 2'b00, 0, 0); // R7
    acc(2'd1, 16'h00F2, 0, 0, 0); chk(7, 0, 2'b00, 0, 0); // R7 GPR bit op
    acc(2'd1, 16'h0010, 1, 0, 0); chk(8, 1, 2'b00, 0, 1); // R8 in window
    edge_step(1, 0, 0);
    acc(2'd0, 16'h0040, 0, 0, 0); chk(2, 1, 2'b00, 0, 0);
    edge_step(1, 0, 0);
    acc(2'd0, 16'h0040, 0, 0, 0); chk(2, 0, 2'b00, 0, 0); // R2 closed

    // R2: longest window, four instructions
    edge_step(1, 1, 2'd3);
    for (int k = 0; k < 4; k++) begin
      acc(2'd0, 16'h0011, 0, 0, 0); chk(2, 1, 2'b00, 0, 0);
      edge_step(1, 0, 0);
    end
    acc(2'd0, 16'h0011, 0, 0, 0); chk(2, 0, 2'b00, 0, 0);

    // R4: reload while open
    edge_step(1, 1, 2'd0);
    edge_step(1, 1, 2'd2);
    for (int k = 0; k < 3; k++) begin
      acc(2'd0, 16'h0011, 0, 0, 0); chk(4, 1, 2'b00, 0, 0);
      edge_step(1, 0, 0);
    end
    acc(2'd0, 16'h0011, 0, 0, 0); chk(4, 0, 2'b00, 0, 0);

    // R1: reset closes an open window
    edge_step(1, 1, 2'd3);
    rst_n = 0; #2; rst_n = 1;
    acc(2'd0, 16'h0040, 0, 0, 0); chk(1, 0, 2'b00, 0, 0);

    // R8: no error without a valid access
    acc_valid = 0; acc_mode = 2'd1; acc_addr = 16'h0010; wr = 1; #2;
    chk(8, 0, 2'b00, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule